// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire open-drain bus. It behaves like a small serial EEPROM with 128 bytes of storage. It has no device-select byte. The first byte after a start carries a 7-bit word address in its upper bits and a direction flag in its lowest bit. The clock and data lines are brought into a fast system clock domain through two-flop synchronisers. Bus edges and bus conditions are then detected from the synchronised copies. The block pulls the data line low through an enable output, and an external pull-up supplies the high level.

A write sends the address byte and one data byte, and a stop then closes it. After the write is committed, the block enters a timed busy interval. During that interval it takes no part in bus traffic. A read sends the address byte and then clocks data out of the slave. Each byte the master acknowledges moves the read pointer on by one, and the pointer wraps from the top of storage back to zero. A start seen in any non-busy state restarts the protocol. This gives the master a way to recover from an interrupted transfer.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the data-line pull-down is released, busy is low, and every storage byte reads back as 0xFF.
- R2: A falling data line while the clock is high is a start condition. In any non-busy state it abandons the current transfer and any partial byte, and it begins a new address byte.
- R3: The address byte is sent MSB first: word address bits 7..1, then the direction bit in bit 0 (1 = read, 0 = write). The slave pulls the data line low during the ninth clock after the address byte and after a write data byte. It does not drive the line while the master is sending bits.
- R4: A write data byte is stored at the addressed location only when a stop condition (rising data line while the clock is high) follows its acknowledge. A start in place of that stop discards the byte.
- R5: On a read, the slave presents the addressed byte MSB first, starting after the falling clock edge that ends the address acknowledge. The slave changes the data line only while the clock is low.
- R6: In a read, a low acknowledge from the master makes the slave send the byte at the next address, modulo 128. A high acknowledge makes the slave release the line and wait for a stop or a start.
- R7: After a committing stop, busy is high for exactly WRITE_CYCLES system clocks. During that time the slave gives no acknowledge, never drives the line, and stores nothing.
- R8: A stop that ends a read returns the slave to idle with busy low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as sensed at the pin |
| sdaIn | input | 1 | Bus data line as sensed at the pin |
| sdaDriveLow | output | 1 | High to pull the data line low (open-drain enable) |
| busy | output | 1 | High during the internal write interval |

## Verification
The assertions assume that the master changes the data line only while the clock is low, except when it forms a start or a stop. They also assume that each clock phase lasts longer than the synchroniser delay plus one cycle. Under those assumptions the pull-down rises and falls only after a detected falling clock edge, and it stays off during busy. The bench keeps to this by holding every bus phase for ten system clocks and moving the data line either with the clock falling edge or while the clock is low. The only exceptions are the deliberate start and stop sequences and the nine-clock recovery sequence.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  typedef struct packed {
    logic shiftIn;
    logic loadAddr;
    logic latchData;
    logic loadTx;
    logic shiftTx;
    logic incAddr;
    logic commit;
  } sbeStrobes_t;
endpackage

// File: rtl/sbe_datapath.sv
module sbe_datapath
  import sbe_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  sbeStrobes_t strb,
  output logic        sclRise,
  output logic        sclFall,
  output logic        startCond,
  output logic        stopCond,
  output logic        sdaBit,
  output logic        rwBit,
  output logic        txBit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0] sclSync, sdaSync;
  logic sclQ, sdaQ, sclNow, sdaNow;
  logic [DATA_W-1:0] shiftReg, dataHold, txReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclNow & ~sclQ;
  assign sclFall   = ~sclNow & sclQ;
  assign startCond = sclNow & sclQ & sdaQ & ~sdaNow;
  assign stopCond  = sclNow & sclQ & ~sdaQ & sdaNow;
  assign sdaBit    = sdaNow;
  assign rwBit     = shiftReg[0];
  assign txBit     = txReg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataHold <= '0;
      txReg    <= '1;
      addrReg  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (strb.shiftIn)   shiftReg <= {shiftReg[DATA_W-2:0], sdaNow};
      if (strb.loadAddr)  addrReg  <= shiftReg[DATA_W-1 -: ADDR_W];
      else if (strb.incAddr) addrReg <= addrReg + ADDR_W'(1);
      if (strb.latchData) dataHold <= shiftReg;
      if (strb.loadTx)    txReg    <= mem[addrReg];
      else if (strb.shiftTx) txReg <= {txReg[DATA_W-2:0], 1'b1};
      if (strb.commit)    mem[addrReg] <= dataHold;
    end
  end

  // R6: pointer steps by one and wraps at the top of storage
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.incAddr && !strb.loadAddr |=> addrReg == $past(addrReg) + ADDR_W'(1));

  // R4: a commit lands the latched byte at the latched address
  a_r4_commit_target: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> mem[$past(addrReg)] == $past(dataHold));
endmodule

// File: rtl/sbe_control.sv
module sbe_control
  import sbe_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startCond,
  input  logic        stopCond,
  input  logic        sdaBit,
  input  logic        rwBit,
  input  logic        txBit,
  output sbeStrobes_t strb,
  output logic        sdaDriveLow,
  output logic        busy
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int WC_W  = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  typedef enum logic [3:0] {
    IDLE, ADDR, ADDR_ACKW, ADDR_ACK, WDAT, WDAT_ACKW, WDAT_ACK,
    HOLD, HOLD_WR, TX_BITS, TX_RACK, TX_NEXT, WR_BUSY
  } ctlState_t;

  ctlState_t state, nxt;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic [WC_W-1:0]  waitCnt, waitNext;

  always_comb begin
    nxt      = state;
    cntNext  = bitCnt;
    waitNext = waitCnt;
    strb     = '0;
    case (state)
      ADDR, WDAT: if (sclRise) begin
        strb.shiftIn = 1'b1;
        if (bitCnt == LAST_BIT) nxt = (state == ADDR) ? ADDR_ACKW : WDAT_ACKW;
        else cntNext = bitCnt + CNT_W'(1);
      end
      ADDR_ACKW: if (sclFall) begin
        strb.loadAddr = 1'b1;
        nxt = ADDR_ACK;
      end
      ADDR_ACK: if (sclFall) begin
        cntNext = '0;
        if (rwBit) begin
          strb.loadTx = 1'b1;
          nxt = TX_BITS;
        end else nxt = WDAT;
      end
      WDAT_ACKW: if (sclFall) begin
        strb.latchData = 1'b1;
        nxt = WDAT_ACK;
      end
      WDAT_ACK: if (sclFall) nxt = HOLD_WR;
      HOLD_WR: if (stopCond) begin
        strb.commit = 1'b1;
        nxt = WR_BUSY;
        waitNext = WC_W'(WRITE_CYCLES - 1);
      end
      TX_BITS: if (sclFall) begin
        if (bitCnt == LAST_BIT) begin
          strb.incAddr = 1'b1;
          nxt = TX_RACK;
        end else begin
          strb.shiftTx = 1'b1;
          cntNext = bitCnt + CNT_W'(1);
        end
      end
      TX_RACK: if (sclRise) nxt = sdaBit ? HOLD : TX_NEXT;
      TX_NEXT: if (sclFall) begin
        strb.loadTx = 1'b1;
        cntNext = '0;
        nxt = TX_BITS;
      end
      WR_BUSY: begin
        if (waitCnt == '0) nxt = IDLE;
        else waitNext = waitCnt - WC_W'(1);
      end
      default: ;
    endcase
    if (state != WR_BUSY) begin
      if (startCond) begin
        nxt = ADDR;
        cntNext = '0;
        strb = '0;
      end else if (stopCond && state != HOLD_WR) begin
        nxt = IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      bitCnt  <= '0;
      waitCnt <= '0;
    end else begin
      state   <= nxt;
      bitCnt  <= cntNext;
      waitCnt <= waitNext;
    end
  end

  assign sdaDriveLow = (state == ADDR_ACK) || (state == WDAT_ACK) ||
                       ((state == TX_BITS) && !txBit);
  assign busy = (state == WR_BUSY);

  // R7: no pull-down while the write interval runs
  a_r7_busy_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaDriveLow);

  // R7: the write interval only opens on a detected stop
  a_r7_busy_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopCond));

  // R5: the line is pulled low only after a bus clock falling edge
  a_r5_drive_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> $past(sclFall));

  // R5: the line is released only after a bus clock falling edge
  a_r5_release_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDriveLow) |-> $past(sclFall));
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import sbe_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow,
  output logic busy
);
  sbeStrobes_t strb;
  logic sclRise, sclFall, startCond, stopCond, sdaBit, rwBit, txBit;

  sbe_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .sclRise(sclRise), .sclFall(sclFall), .startCond(startCond),
    .stopCond(stopCond), .sdaBit(sdaBit), .rwBit(rwBit), .txBit(txBit)
  );

  sbe_control #(.DATA_W(DATA_W), .WRITE_CYCLES(WRITE_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .sdaBit(sdaBit),
    .rwBit(rwBit), .txBit(txBit), .strb(strb),
    .sdaDriveLow(sdaDriveLow), .busy(busy)
  );
endmodule

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;
  localparam int WR_CYC = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow, busy, sdaLine;

  int tests = 0, fails = 0;
  int relViol = 0, busyViol = 0, stableErr = 0;
  int busyCnt = 0, lastBusyLen = 0;
  bit mustRelease = 1'b0;
  logic [7:0] model [128];

  assign sdaLine = sdaM & ~sdaDriveLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_eeprom_slave #(.WRITE_CYCLES(WR_CYC)) uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .busy(busy)
  );

  // per-clock comparison against the behavioural expectations
  always @(negedge clk) begin
    if (mustRelease && sdaDriveLow) relViol++;
    if (busy && sdaDriveLow) busyViol++;
    if (busy) busyCnt++;
    else if (busyCnt != 0) begin
      lastBusyLen = busyCnt;
      busyCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; w(HALF);
    scl = 1'b1; w(HALF);
    sdaM = 1'b0; w(HALF);
    scl = 1'b0; w(HALF);
  endtask

  task automatic busStop();
    sdaM = 1'b0; w(HALF);
    scl = 1'b1; w(HALF);
    sdaM = 1'b1; w(HALF);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; w(HALF);
    mustRelease = 1'b1;
    scl = 1'b1; w(HALF);
    scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    mustRelease = 1'b0;
    sdaM = 1'b1; w(HALF);
    scl = 1'b1; w(HALF/2);
    acked = !sdaLine;
    w(HALF/2);
    scl = 1'b0;
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] v);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic a, b;
      w(HALF);
      scl = 1'b1; w(HALF/2);
      a = sdaLine;
      w(HALF/2 - 1);
      b = sdaLine;
      if (a != b) stableErr++;
      w(1);
      scl = 1'b0;
      v[i] = a;
    end
    sdaM = giveAck ? 1'b0 : 1'b1; w(HALF);
    scl = 1'b1; w(HALF);
    scl = 1'b0;
    sdaM = 1'b1;
  endtask

  task automatic waitIdle();
    w(5);
    while (busy) @(negedge clk);
    w(HALF);
  endtask

  task automatic writeOp(input logic [6:0] a, input logic [7:0] d, output bit k1, output bit k2);
    busStart();
    sendByte({a, 1'b0}, k1);
    sendByte(d, k2);
    busStop();
  endtask

  task automatic readOne(input logic [6:0] a, output logic [7:0] v, output bit k);
    busStart();
    sendByte({a, 1'b1}, k);
    readByte(1'b0, v);
    busStop();
  endtask

  task automatic recover();
    sdaM = 1'b1;
    for (int i = 0; i < 9; i++) begin
      logic hi;
      w(HALF);
      scl = 1'b1; w(HALF);
      hi = sdaLine;
      if (hi) break;
      scl = 1'b0;
    end
    sdaM = 1'b0; w(HALF);
    scl = 1'b0; w(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit k1, k2;
    logic [7:0] v, v2;
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    w(5);
    rstN = 1'b1;
    w(5);

    // R1 reset state
    chk(sdaDriveLow == 1'b0, "R1 drive after reset", sdaDriveLow, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);

    // R1 erased content
    readOne(7'h05, v, k1);
    chk(k1, "R3 read address ack", k1, 1);
    chk(v == model[5], "R1 erased byte", v, model[5]);
    chk(busy == 1'b0, "R8 no busy after read stop", busy, 0);

    // R3/R4/R7 byte write and busy length
    writeOp(7'h10, 8'h5A, k1, k2);
    model[16] = 8'h5A;
    chk(k1, "R3 write address ack", k1, 1);
    chk(k2, "R3 write data ack", k2, 1);
    waitIdle();
    chk(lastBusyLen == WR_CYC, "R7 busy length", lastBusyLen, WR_CYC);
    readOne(7'h10, v, k1);
    chk(v == model[16], "R4 R5 readback", v, model[16]);

    // R7 inputs ignored while busy
    writeOp(7'h20, 8'h77, k1, k2);
    model[32] = 8'h77;
    busStart();
    sendByte({7'h20, 1'b0}, k1);
    chk(!k1, "R7 no ack while busy", k1, 0);
    sendByte(8'h00, k2);
    chk(!k2, "R7 no data ack after busy", k2, 0);
    busStop();
    waitIdle();
    chk(busy == 1'b0, "R7 ignored write raises no busy", busy, 0);
    readOne(7'h20, v, k1);
    chk(v == model[32], "R7 ignored write stored nothing", v, model[32]);
    chk(busyViol == 0, "R7 drive during busy", busyViol, 0);

    // R6 sequential read with wrap
    writeOp(7'h7F, 8'h33, k1, k2); model[127] = 8'h33; waitIdle();
    writeOp(7'h00, 8'h44, k1, k2); model[0] = 8'h44; waitIdle();
    busStart();
    sendByte({7'h7F, 1'b1}, k1);
    readByte(1'b1, v);
    readByte(1'b0, v2);
    busStop();
    chk(v == model[127], "R6 first of burst", v, model[127]);
    chk(v2 == model[0], "R6 wrap to zero", v2, model[0]);
    w(HALF);
    chk(busy == 1'b0, "R8 stop after read idle", busy, 0);
    chk(sdaDriveLow == 1'b0, "R6 released after nack", sdaDriveLow, 0);

    // R4 repeated start discards write data
    busStart();
    sendByte({7'h30, 1'b0}, k1);
    sendByte(8'h99, k2);
    chk(k2, "R3 data ack before restart", k2, 1);
    busStart();
    sendByte({7'h30, 1'b1}, k1);
    chk(k1, "R2 address ack after restart", k1, 1);
    readByte(1'b0, v);
    busStop();
    chk(v == model[48], "R4 uncommitted byte discarded", v, model[48]);
    chk(busy == 1'b0, "R4 no busy without stop commit", busy, 0);

    // R2 restart mid address byte
    busStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    mustRelease = 1'b0;
    busStart();
    sendByte({7'h10, 1'b1}, k1);
    readByte(1'b0, v);
    busStop();
    chk(v == model[16], "R2 restart mid byte", v, model[16]);

    // R2 recovery from interrupted read (first bit of 0x77 is low)
    busStart();
    sendByte({7'h20, 1'b1}, k1);
    sdaM = 1'b1; w(HALF);
    scl = 1'b1; w(HALF);
    scl = 1'b0;
    recover();
    sendByte({7'h10, 1'b1}, k1);
    readByte(1'b0, v);
    busStop();
    chk(k1, "R2 ack after recovery", k1, 1);
    chk(v == model[16], "R2 data after recovery", v, model[16]);

    chk(relViol == 0, "R3 slave quiet during master bits", relViol, 0);
    chk(stableErr == 0, "R5 data stable while clock high", stableErr, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule